// File: doc/BRIEF.md
# Memory Map Address Decoder

This block turns a 16-bit processor address into chip enables for three targets on the bus: a 32K RAM region, a 16K ROM region and a single small I/O device. It is purely combinational. When an address falls outside all three, a separate flag is raised and no enable is driven. It also hands each target the low address bits it needs to pick a location inside itself. RAM and ROM receive a 12-bit offset. The I/O device receives a 2-bit register select.

RAM and ROM are chosen from the top nibble of the address, one 4K page per nibble value. RAM covers pages 0 to 7. ROM covers pages 11 to 14. The ROM range does not start on a power-of-two boundary, so it is matched with a range compare rather than a plain bit test. The I/O device uses only four bytes, which means all address bits except the lowest two must match its base.

There is no stream data path, so there is no valid/ready handshake and no back-pressure. Every output follows the address input within the same cycle.

Top module: `mem_map_decoder`

## Requirements
- R1: `ram_ce` is 1 exactly when the address is in 0x0000..0x7FFF (top nibble 0 through 7).
- R2: `rom_ce` is 1 exactly when the top nibble is 0xB through 0xE inclusive, that is 0xB000..0xEFFF.
- R3: `io_ce` is 1 exactly when the address is in 0xF574..0xF577, meaning bits 15..2 equal 0xF574 >> 2.
- R4: For every address at most one of `ram_ce`, `rom_ce` and `io_ce` is 1.
- R5: `unmapped` is 1 exactly when none of the three enables is 1. This covers 0x8000..0xAFFF, 0xF000..0xF573 and 0xF578..0xFFFF.
- R6: `dev_offset` equals address bits 11..0 whenever `ram_ce` or `rom_ce` is 1, and is zero otherwise.
- R7: `io_reg` equals address bits 1..0 whenever `io_ce` is 1, and is zero otherwise.
- R8: Each single-address boundary of the map decodes to the correct side: 0x7FFF/0x8000, 0xAFFF/0xB000, 0xEFFF/0xF000, 0xF573/0xF574 and 0xF577/0xF578.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address |
| ram_ce | output | 1 | RAM region enable |
| rom_ce | output | 1 | ROM region enable |
| io_ce | output | 1 | I/O device enable |
| unmapped | output | 1 | No region matched the address |
| dev_offset | output | 12 | Location within the selected RAM or ROM page, zero otherwise |
| io_reg | output | 2 | Register select for the I/O device, zero otherwise |

## Verification
The hardest cases to reach are the edges of the four-byte I/O window. These are 0xF573 and 0xF578, which lie inside a page that is otherwise unmapped. A single wrong bit in the 14-bit tag compare would shift or widen the window only by a few addresses. The bench therefore steps through every one of the 65536 addresses. For each one it compares the outputs with plain arithmetic range tests. It also runs separate named checks at each boundary pair.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RAM  = 2'd1,
    SEL_ROM  = 2'd2,
    SEL_IO   = 2'd3
  } region_sel_e;
endpackage

// File: rtl/page_range_match.sv
// Inclusive range compare on the page index (upper address bits).
module page_range_match #(
  parameter int PAGE_W = 4,
  parameter int LO_PG  = 0,
  parameter int HI_PG  = 7
) (
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  localparam int MAX_PG = (1 << PAGE_W) - 1;
  localparam logic [PAGE_W-1:0] LO_V = PAGE_W'(LO_PG);
  localparam logic [PAGE_W-1:0] HI_V = PAGE_W'(HI_PG);

  // Drop a compare that is always true, so no constant bound is left behind.
  generate
    if (LO_PG == 0 && HI_PG == MAX_PG) begin : g_all
      logic unused_pg;
      assign unused_pg = ^page;
      assign hit = 1'b1;
    end else if (LO_PG == 0) begin : g_upper
      assign hit = (page <= HI_V);
    end else if (HI_PG == MAX_PG) begin : g_lower
      assign hit = (page >= LO_V);
    end else begin : g_both
      assign hit = (page >= LO_V) && (page <= HI_V);
    end
  endgenerate
endmodule

// File: rtl/window_match.sv
// Exact tag compare for a small power-of-two window.
module window_match #(
  parameter int                ADDR_W = 16,
  parameter int                SEL_W  = 2,
  parameter logic [ADDR_W-1:0] BASE   = 16'hF574
) (
  input  logic [ADDR_W-1:SEL_W] tag,
  output logic                  hit
);
  localparam logic [ADDR_W-1:SEL_W] TAG_V = BASE[ADDR_W-1:SEL_W];
  assign hit = (tag == TAG_V);
endmodule

// File: rtl/region_select.sv
// Turns the raw region matches into one enable and routes the low address bits.
module region_select
  import mmap_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int SEL_W = 2
) (
  input  logic             ram_hit,
  input  logic             rom_hit,
  input  logic             io_hit,
  input  logic [OFF_W-1:0] low_addr,
  output logic             ram_ce,
  output logic             rom_ce,
  output logic             io_ce,
  output logic             unmapped,
  output logic [OFF_W-1:0] dev_offset,
  output logic [SEL_W-1:0] io_reg
);
  region_sel_e sel;

  // Fixed priority: the narrowest region wins if parameters ever overlap.
  always_comb begin
    if (io_hit)       sel = SEL_IO;
    else if (rom_hit) sel = SEL_ROM;
    else if (ram_hit) sel = SEL_RAM;
    else              sel = SEL_NONE;
  end

  always_comb begin
    ram_ce     = (sel == SEL_RAM);
    rom_ce     = (sel == SEL_ROM);
    io_ce      = (sel == SEL_IO);
    unmapped   = (sel == SEL_NONE);
    dev_offset = '0;
    io_reg     = '0;
    case (sel)
      SEL_RAM, SEL_ROM: dev_offset = low_addr;
      SEL_IO:           io_reg     = low_addr[SEL_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder #(
  parameter int                ADDR_W    = 16,
  parameter int                PAGE_W    = 4,
  parameter int                RAM_LO_PG = 0,
  parameter int                RAM_HI_PG = 7,
  parameter int                ROM_LO_PG = 11,
  parameter int                ROM_HI_PG = 14,
  parameter logic [ADDR_W-1:0] IO_BASE   = 16'hF574,
  parameter int                IO_SEL_W  = 2,
  localparam int               OFF_W     = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                ram_ce,
  output logic                rom_ce,
  output logic                io_ce,
  output logic                unmapped,
  output logic [OFF_W-1:0]    dev_offset,
  output logic [IO_SEL_W-1:0] io_reg
);
  logic ram_hit, rom_hit, io_hit;
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:OFF_W];

  page_range_match #(.PAGE_W(PAGE_W), .LO_PG(RAM_LO_PG), .HI_PG(RAM_HI_PG))
    u_ram_match (.page(page), .hit(ram_hit));

  page_range_match #(.PAGE_W(PAGE_W), .LO_PG(ROM_LO_PG), .HI_PG(ROM_HI_PG))
    u_rom_match (.page(page), .hit(rom_hit));

  window_match #(.ADDR_W(ADDR_W), .SEL_W(IO_SEL_W), .BASE(IO_BASE))
    u_io_match (.tag(addr[ADDR_W-1:IO_SEL_W]), .hit(io_hit));

  region_select #(.OFF_W(OFF_W), .SEL_W(IO_SEL_W)) u_sel (
    .ram_hit    (ram_hit),
    .rom_hit    (rom_hit),
    .io_hit     (io_hit),
    .low_addr   (addr[OFF_W-1:0]),
    .ram_ce     (ram_ce),
    .rom_ce     (rom_ce),
    .io_ce      (io_ce),
    .unmapped   (unmapped),
    .dev_offset (dev_offset),
    .io_reg     (io_reg)
  );

  always_comb begin
    a_r4_one_enable: assert ($onehot0({ram_ce, rom_ce, io_ce}));
    // R5: a flagged miss must coincide with no raw match at all.
    if (unmapped)
      a_r5_miss_means_no_match: assert (!ram_hit && !rom_hit && !io_hit);
    // R3: the I/O enable only for addresses whose tag equals the base tag.
    if (io_ce)
      a_r3_io_tag: assert (addr[ADDR_W-1:IO_SEL_W] == IO_BASE[ADDR_W-1:IO_SEL_W]);
    // R6: a non-zero offset only reaches a memory that is selected.
    if (dev_offset != '0)
      a_r6_offset_gated: assert (ram_ce || rom_ce);
    // R7: a non-zero register select only reaches a selected I/O device.
    if (io_reg != '0)
      a_r7_reg_gated: assert (io_ce);
  end
endmodule

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] addr = '0;
  logic        ram_ce, rom_ce, io_ce, unmapped;
  logic [11:0] dev_offset;
  logic [1:0]  io_reg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mem_map_decoder uut (
    .addr(addr), .ram_ce(ram_ce), .rom_ce(rom_ce), .io_ce(io_ce),
    .unmapped(unmapped), .dev_offset(dev_offset), .io_reg(io_reg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic check_addr(input logic [15:0] a);
    logic e_ram, e_rom, e_io, e_un;
    logic [11:0] e_off;
    logic [1:0]  e_reg;
    e_ram = (a < 16'h8000);
    e_rom = (a >= 16'hB000) && (a <= 16'hEFFF);
    e_io  = (a >= 16'hF574) && (a <= 16'hF577);
    e_un  = !(e_ram || e_rom || e_io);
    e_off = (e_ram || e_rom) ? (a % 4096) : 12'd0;
    e_reg = e_io ? 2'(a % 4) : 2'd0;
    @(posedge clk);
    addr = a;
    @(negedge clk);
    check("R1", 32'(ram_ce), 32'(e_ram));
    check("R2", 32'(rom_ce), 32'(e_rom));
    check("R3", 32'(io_ce), 32'(e_io));
    check("R4", 32'(ram_ce) + 32'(rom_ce) + 32'(io_ce) <= 1 ? 32'd1 : 32'd0, 32'd1);
    check("R5", 32'(unmapped), 32'(e_un));
    check("R6", 32'(dev_offset), 32'(e_off));
    check("R7", 32'(io_reg), 32'(e_reg));
  endtask

  task automatic check_edge(input logic [15:0] a, input logic [3:0] exp_vec);
    @(posedge clk);
    addr = a;
    @(negedge clk);
    // R8: the vector is {ram_ce, rom_ce, io_ce, unmapped}.
    check("R8", 32'({ram_ce, rom_ce, io_ce, unmapped}), 32'(exp_vec));
  endtask

  initial begin
    // Initial state with address 0: RAM selected, offset zero.
    @(negedge clk);
    check("R1", 32'({ram_ce, rom_ce, io_ce, unmapped}), 32'b1000);
    check_edge(16'h7FFF, 4'b1000);
    check_edge(16'h8000, 4'b0001);
    check_edge(16'hAFFF, 4'b0001);
    check_edge(16'hB000, 4'b0100);
    check_edge(16'hEFFF, 4'b0100);
    check_edge(16'hF000, 4'b0001);
    check_edge(16'hF573, 4'b0001);
    check_edge(16'hF574, 4'b0010);
    check_edge(16'hF577, 4'b0010);
    check_edge(16'hF578, 4'b0001);
    check_edge(16'hFFFF, 4'b0001);
    for (int a = 0; a < 65536; a++) check_addr(16'(a));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule